// File: doc/BRIEF.md
# External Interrupt Sense Converter

This block sits between 32 interrupt wires coming from outside the chip and a downstream interrupt controller that only accepts active-high levels. Every input line is brought into the local clock domain through a two-stage synchroniser. Each line can be set up on its own as level-high, level-low, rising-edge or falling-edge. Edge events are caught in a per-line request latch, which holds until software clears it. Level requests follow the synchronised pin.

A per-line mask gates each request before it reaches a registered, active-high output. Masking does not discard a latched edge. A software-interrupt register lets software raise any line's request directly.

Software reaches the block through a plain word-addressed register port. A write takes effect on the clock edge where the write enable is high. Read data is combinational from the word address. The byte offset of a register is its word address times four. The word addresses are:

| Word address | Register |
|---|---|
| 0 | mask |
| 1 | source select |
| 2 | masked status |
| 3 | raw status |
| 4 | clear |
| 5 | polarity |
| 6 | edge mode |
| 7 | software interrupt |

In every register, bit n belongs to line n.

Top module: `ext_irq_conv`

## Requirements
- R1: After reset every mask bit reads 1. Polarity, edge mode, source select and software interrupt all read 0. Every output is low.
- R2: With edge mode 0 and polarity 1, an unmasked line's output is high while its input is high, and low after the input returns low.
- R3: With edge mode 0 and polarity 0, an unmasked line's output is high while its input is low, and low while the input is high.
- R4: With edge mode 1 and polarity 1, a rising input edge sets a latched request. The request stays set after the input falls.
- R5: With edge mode 1 and polarity 0, a falling input edge sets a latched request. A rising edge does not set it.
- R6: Writing 1 to bit n of the clear register (word 4) clears line n's latched request. Writing 0 to bit n leaves it set.
- R7: An edge that arrives while a line is masked keeps its latched request. The output drives high once the line is unmasked, unless the request was cleared first.
- R8: Raw status (word 3) shows each request before masking. Masked status (word 2) shows raw status AND NOT mask. An output is never high while its mask bit is 1.
- R9: For a line in level mode, a clear-register write does not lower an active request.
- R10: Bit n set in the software interrupt register (word 7) raises line n's request whatever its input. Clearing the bit removes that request.
- R11: Source select, mask, polarity, edge mode and software interrupt read back the last value written. The clear register reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | NUM_LINES | Asynchronous external interrupt lines |
| reg_word | input | 3 | Register word address |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | NUM_LINES | Register write data |
| reg_rdata | output | NUM_LINES | Register read data for reg_word |
| irq_out | output | NUM_LINES | Active-high level requests to the downstream controller |

## Verification
The hardest case to reach from the ports is an edge request that survives masking. The line has to be masked, then see a complete pulse on its pin, and only then be unmasked, with no clear write in between.

The stimulus first masks every line, puts line 20 in rising-edge mode and clears it. It then pulses the pin and lets the synchroniser settle. While the line is still masked, the bench reads raw and masked status. It then unmasks the line and watches the output rise. A separate falling-edge scenario writes a clear word that has every bit set except the pending line's. This shows that zero bits in the clear register leave a latched request alone.

// File: rtl/ext_irq_pkg.sv
// Package: shared register word addresses for the external interrupt converter.
// Assumes a word-addressed register port; the byte offset is word * 4.
package ext_irq_pkg;

    typedef enum logic [2:0] {
        REG_MASK   = 3'd0,
        REG_SRCSEL = 3'd1,
        REG_STAT   = 3'd2,
        REG_RAW    = 3'd3,
        REG_CLR    = 3'd4,
        REG_POL    = 3'd5,
        REG_EDGE   = 3'd6,
        REG_SWI    = 3'd7
    } reg_word_e;

    localparam int SYNC_STAGES = 2;

endpackage

// File: rtl/irq_sync.sv
// Module: irq_sync
// Brings WIDTH asynchronous lines into the clk domain through a chain of
// STAGES flops per line.
// Assumes each input pulse stays high or low for at least two clock cycles.
module irq_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] chain [STAGES];

    // first stage captures the raw pins
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= '0;
        else        chain[0] <= async_in;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        // each further stage resamples the previous one
        always_ff @(posedge clk) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
        end
    end

    assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/irq_line.sv
// Module: irq_line
// Sense logic for one interrupt line: level or edge, either polarity.
// In edge mode a detected edge sets a latch that only a clear pulse removes.
// An edge and a clear in the same cycle leave the latch set, so no event is lost.
// In level mode the latch is held empty and the request follows the pin.
// The software-interrupt bit is ORed into the request.
// Assumes sync_in is already synchronised to clk.
module irq_line (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    input  logic pol,
    input  logic edge_mode,
    input  logic clr,
    input  logic swi,
    output logic raw
);

    logic prev_q;
    logic lat_q;
    logic edge_det;
    logic level_act;

    // remember the previous synchronised sample for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_in;
    end

    // detect the selected edge and compute the polarity-corrected level
    always_comb begin
        edge_det  = pol ? (sync_in & ~prev_q) : (~sync_in & prev_q);
        level_act = ~(sync_in ^ pol);
    end

    // latch edge requests: set wins over clear, level mode empties the latch
    always_ff @(posedge clk) begin
        if (!rst_n)              lat_q <= 1'b0;
        else if (!edge_mode)     lat_q <= 1'b0;
        else if (edge_det)       lat_q <= 1'b1;
        else if (clr)            lat_q <= 1'b0;
    end

    // pick the request source for this line
    always_comb begin
        raw = (edge_mode ? lat_q : level_act) | swi;
    end

    AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && edge_det) |=> lat_q) else $error("edge lost");          // R4
    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && clr && !edge_det) |=> !lat_q) else $error("clear ignored"); // R6
    AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && lat_q && !clr) |=> (lat_q || !edge_mode || $past(!edge_mode))) else $error("latch dropped"); // R7

endmodule

// File: rtl/irq_regs.sv
// Module: irq_regs
// Register file for the converter: mask, source select, polarity,
// edge mode and software interrupt storage, a one-cycle clear pulse,
// and combinational readback by word address.
// Assumes one write at most per cycle; a read has no side effects.
module irq_regs
    import ext_irq_pkg::*;
#(
    parameter int NUM_LINES = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2:0]           reg_word,
    input  logic                 reg_we,
    input  logic [NUM_LINES-1:0] reg_wdata,
    input  logic [NUM_LINES-1:0] raw,
    output logic [NUM_LINES-1:0] reg_rdata,
    output logic [NUM_LINES-1:0] mask,
    output logic [NUM_LINES-1:0] pol,
    output logic [NUM_LINES-1:0] edge_mode,
    output logic [NUM_LINES-1:0] swi,
    output logic [NUM_LINES-1:0] clr
);

    logic [NUM_LINES-1:0] srcsel_q;
    reg_word_e            sel;

    assign sel = reg_word_e'(reg_word);

    // store the writable configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask      <= '1;
            srcsel_q  <= '0;
            pol       <= '0;
            edge_mode <= '0;
            swi       <= '0;
        end else if (reg_we) begin
            case (sel)
                REG_MASK:   mask      <= reg_wdata;
                REG_SRCSEL: srcsel_q  <= reg_wdata;
                REG_POL:    pol       <= reg_wdata;
                REG_EDGE:   edge_mode <= reg_wdata;
                REG_SWI:    swi       <= reg_wdata;
                default:    ;
            endcase
        end
    end

    // turn a clear-register write into a single-cycle pulse
    always_comb begin
        clr = (reg_we && sel == REG_CLR) ? reg_wdata : '0;
    end

    // return the addressed register
    always_comb begin
        case (sel)
            REG_MASK:   reg_rdata = mask;
            REG_SRCSEL: reg_rdata = srcsel_q;
            REG_STAT:   reg_rdata = raw & ~mask;
            REG_RAW:    reg_rdata = raw;
            REG_POL:    reg_rdata = pol;
            REG_EDGE:   reg_rdata = edge_mode;
            REG_SWI:    reg_rdata = swi;
            default:    reg_rdata = '0;
        endcase
    end

    AST_CLR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == REG_CLR) |-> (reg_rdata == '0)) else $error("clear readback"); // R11

endmodule

// File: rtl/ext_irq_conv.sv
// Module: ext_irq_conv (top)
// Converts NUM_LINES external interrupts of any sense type into registered,
// masked, active-high level requests for a downstream controller.
// Assumes synchronous active-low reset, and that irq_in is asynchronous to clk.
module ext_irq_conv
    import ext_irq_pkg::*;
#(
    parameter int NUM_LINES = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic [2:0]           reg_word,
    input  logic                 reg_we,
    input  logic [NUM_LINES-1:0] reg_wdata,
    output logic [NUM_LINES-1:0] reg_rdata,
    output logic [NUM_LINES-1:0] irq_out
);

    logic [NUM_LINES-1:0] sync_in;
    logic [NUM_LINES-1:0] raw;
    logic [NUM_LINES-1:0] mask;
    logic [NUM_LINES-1:0] pol;
    logic [NUM_LINES-1:0] edge_mode;
    logic [NUM_LINES-1:0] swi;
    logic [NUM_LINES-1:0] clr;

    irq_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (irq_in),
        .sync_out (sync_in)
    );

    for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
        irq_line u_line (
            .clk       (clk),
            .rst_n     (rst_n),
            .sync_in   (sync_in[n]),
            .pol       (pol[n]),
            .edge_mode (edge_mode[n]),
            .clr       (clr[n]),
            .swi       (swi[n]),
            .raw       (raw[n])
        );
    end

    irq_regs #(.NUM_LINES(NUM_LINES)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_word  (reg_word),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .raw       (raw),
        .reg_rdata (reg_rdata),
        .mask      (mask),
        .pol       (pol),
        .edge_mode (edge_mode),
        .swi       (swi),
        .clr       (clr)
    );

    // register the masked requests so the outputs are glitch-free levels
    always_ff @(posedge clk) begin
        if (!rst_n) irq_out <= '0;
        else        irq_out <= raw & ~mask;
    end

    AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((irq_out & $past(mask)) == '0)) else $error("masked line drove output"); // R8

endmodule

// File: tb/tb_ext_irq_conv.sv
`timescale 1ns/1ps
module tb_ext_irq_conv;

    localparam int N = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] irq_in = '0;
    logic [2:0]   reg_word = '0;
    logic         reg_we = 1'b0;
    logic [N-1:0] reg_wdata = '0;
    logic [N-1:0] reg_rdata;
    logic [N-1:0] irq_out;

    int checks = 0;
    int errors = 0;

    logic [N-1:0] sh_mask = '1;
    logic [N-1:0] sh_pol  = '0;
    logic [N-1:0] sh_edge = '0;

    always #2.5 clk = ~clk;

    ext_irq_conv #(.NUM_LINES(N)) dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_word(reg_word),
        .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_out(irq_out)
    );

    task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] w, input logic [N-1:0] d);
        @(negedge clk);
        reg_word = w; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] w, output logic [N-1:0] d);
        @(negedge clk);
        reg_word = w;
        #1 d = reg_rdata;
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    task automatic setup_line(input int n, input bit p, input bit e);
        sh_pol[n] = p; sh_edge[n] = e;
        wr(3'd5, sh_pol);
        wr(3'd6, sh_edge);
        wr(3'd4, N'(1) << n);
        sh_mask[n] = 1'b0;
        wr(3'd0, sh_mask);
    endtask

    task automatic t_reset();
        logic [N-1:0] d;
        chk("R1 irq_out", irq_out, '0);
        rd(3'd0, d); chk("R1 mask", d, '1);
        rd(3'd5, d); chk("R1 pol", d, '0);
        rd(3'd6, d); chk("R1 edge", d, '0);
        rd(3'd1, d); chk("R1 srcsel", d, '0);
        rd(3'd7, d); chk("R1 swi", d, '0);
    endtask

    task automatic t_level_high();
        setup_line(3, 1'b1, 1'b0);
        settle(); chk("R2 idle", irq_out & (N'(1) << 3), '0);
        irq_in[3] = 1'b1; settle();
        chk("R2 high", irq_out & (N'(1) << 3), N'(1) << 3);
        irq_in[3] = 1'b0; settle();
        chk("R2 low", irq_out & (N'(1) << 3), '0);
    endtask

    task automatic t_level_low();
        setup_line(7, 1'b0, 1'b0);
        settle(); chk("R3 active low", irq_out & (N'(1) << 7), N'(1) << 7);
        wr(3'd4, N'(1) << 7); settle();
        chk("R9 level clear", irq_out & (N'(1) << 7), N'(1) << 7);
        irq_in[7] = 1'b1; settle();
        chk("R3 inactive", irq_out & (N'(1) << 7), '0);
    endtask

    task automatic t_rising();
        setup_line(10, 1'b1, 1'b1);
        settle(); chk("R4 idle", irq_out & (N'(1) << 10), '0);
        irq_in[10] = 1'b1; settle();
        chk("R4 set", irq_out & (N'(1) << 10), N'(1) << 10);
        irq_in[10] = 1'b0; settle();
        chk("R4 held", irq_out & (N'(1) << 10), N'(1) << 10);
        wr(3'd4, N'(1) << 10); settle();
        chk("R6 cleared", irq_out & (N'(1) << 10), '0);
    endtask

    task automatic t_falling();
        irq_in[12] = 1'b1; settle();
        setup_line(12, 1'b0, 1'b1);
        settle(); chk("R5 no rise", irq_out & (N'(1) << 12), '0);
        irq_in[12] = 1'b0; settle();
        chk("R5 fall", irq_out & (N'(1) << 12), N'(1) << 12);
        wr(3'd4, ~(N'(1) << 12)); settle();
        chk("R6 zero bit", irq_out & (N'(1) << 12), N'(1) << 12);
        wr(3'd4, N'(1) << 12); settle();
        chk("R6 one bit", irq_out & (N'(1) << 12), '0);
    endtask

    task automatic t_masked();
        logic [N-1:0] d;
        sh_pol[20] = 1'b1; sh_edge[20] = 1'b1;
        wr(3'd5, sh_pol); wr(3'd6, sh_edge);
        wr(3'd4, N'(1) << 20);
        irq_in[20] = 1'b1; settle();
        irq_in[20] = 1'b0; settle();
        chk("R7 masked out", irq_out & (N'(1) << 20), '0);
        rd(3'd3, d); chk("R8 raw", d & (N'(1) << 20), N'(1) << 20);
        rd(3'd2, d); chk("R8 status masked", d & (N'(1) << 20), '0);
        sh_mask[20] = 1'b0; wr(3'd0, sh_mask); settle();
        chk("R7 unmasked", irq_out & (N'(1) << 20), N'(1) << 20);
        rd(3'd2, d); chk("R8 status", d & (N'(1) << 20), N'(1) << 20);
    endtask

    task automatic t_swi();
        setup_line(25, 1'b1, 1'b0);
        settle(); chk("R10 idle", irq_out & (N'(1) << 25), '0);
        wr(3'd7, N'(1) << 25); settle();
        chk("R10 forced", irq_out & (N'(1) << 25), N'(1) << 25);
        wr(3'd7, '0); settle();
        chk("R10 released", irq_out & (N'(1) << 25), '0);
    endtask

    task automatic t_readback();
        logic [N-1:0] d;
        wr(3'd1, 32'hA5C3_0F96); rd(3'd1, d); chk("R11 srcsel", d, 32'hA5C3_0F96);
        rd(3'd0, d); chk("R11 mask", d, sh_mask);
        rd(3'd5, d); chk("R11 pol", d, sh_pol);
        rd(3'd6, d); chk("R11 edge", d, sh_edge);
        wr(3'd7, 32'h0000_8001); rd(3'd7, d); chk("R11 swi", d, 32'h0000_8001);
        wr(3'd7, '0);
        rd(3'd4, d); chk("R11 clear reads 0", d, '0);
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_level_high();
        t_level_low();
        t_rising();
        t_falling();
        t_masked();
        t_swi();
        t_readback();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule